// File: doc/BRIEF.md
# Hardware Time-of-Day Clock

This block keeps time for a packet timestamping path. On every clock edge it advances two counters by a per-cycle increment held in units of 1/65536 ns. The first counter is a time-of-day value made of whole seconds, nanoseconds and fractional nanoseconds. The nanosecond field rolls over at one billion, and the seconds field then counts up. The second counter is a flat relative nanosecond count that never rolls over at a second.

The increment is a fixed-point period made of an integer nanosecond part and a 16-bit fraction. On top of that period sits a rational drift term: an extra `num` fractional units once every `den` cycles. With this term the average rate can match a clock period such as 6.4 ns, which the fraction alone cannot represent exactly. The defaults come from a numerator/denominator parameter pair. For 32/5 ns they give 6 ns + 0x6666 fractional units, with a drift of 2 every 5 cycles.

Control logic can do four things: load either counter, replace the period, replace the drift term, and apply an offset. The offset is a nanosecond-plus-fraction amount added on each of a given number of cycles. The outputs carry the two counters, a one-cycle flag after each load, a one-cycle pulse on each seconds rollover, and a busy flag while an offset is being applied.

Top module: `ptp_tod_clock`

## Requirements
- R1: While `rst_ni` is low, and on the first falling edge after it goes low, both counters read zero and every flag is low. After reset the increment is the parameter default. With the default parameters the relative count is exactly 10000*32*65536/5 fractional units after 10000 cycles.
- R2: On each edge without a load, both counters grow by the same increment. The increment is the period `{ns, fns}` plus the drift extra due on that cycle plus the offset amount while an offset is active.
- R3: The drift term adds `num` fractional units on every `den`-th cycle. A drift update loads new `num` and `den`, restarts the phase at zero, and takes effect from the cycle after its strobe. A `den` of zero turns the drift term off.
- R4: A period update takes effect for the increment of the cycle after its strobe.
- R5: A time-of-day load is visible on the cycle after its strobe, and `tod_step_o` is high for exactly that cycle. A loaded nanosecond field of one billion or more is saturated to 999999999.
- R6: A relative load replaces `rel_o` on the cycle after its strobe and raises `rel_step_o` for that cycle. It has no effect on the time-of-day counter.
- R7: The nanosecond field never shows a value of one billion or more. When a sum reaches one billion, one billion is subtracted in the same cycle and the seconds field goes up by one. `pps_o` is high for exactly the cycle that shows the new second.
- R8: The relative counter runs past one billion nanoseconds without wrapping.
- R9: An offset strobe with count N adds `{adj_ns, adj_fns}` on each of the next N edges. `adj_active_o` is high for exactly those N cycles. A count of zero has no effect.
- R10: `tod_o` holds seconds in bits [95:48], nanoseconds in [47:16] and fractional nanoseconds in [15:0]. `rel_o` holds nanoseconds in [63:16] and the fraction in [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tod_load_i | input | 96 | Time-of-day value to load (R10 layout) |
| tod_load_valid_i | input | 1 | Time-of-day load strobe |
| rel_load_i | input | 64 | Relative value to load |
| rel_load_valid_i | input | 1 | Relative load strobe |
| period_ns_i | input | 4 | New period, integer nanoseconds |
| period_fns_i | input | 16 | New period, fractional nanoseconds |
| period_valid_i | input | 1 | Period update strobe |
| adj_ns_i | input | 16 | Offset per cycle, nanoseconds |
| adj_fns_i | input | 16 | Offset per cycle, fractional nanoseconds |
| adj_count_i | input | 16 | Number of cycles the offset is applied |
| adj_valid_i | input | 1 | Offset strobe |
| drift_num_i | input | 16 | Drift units added per drift event |
| drift_den_i | input | 16 | Cycles between drift events |
| drift_valid_i | input | 1 | Drift update strobe |
| tod_o | output | 96 | Time-of-day counter |
| tod_step_o | output | 1 | One cycle after a time-of-day load |
| rel_o | output | 64 | Relative counter |
| rel_step_o | output | 1 | One cycle after a relative load |
| pps_o | output | 1 | One-cycle pulse on a seconds rollover |
| adj_active_o | output | 1 | Offset being applied |

## Verification
A load and its step flag appear one edge after the strobe. A period or drift update changes the counters on the second edge after its strobe, because the new value only feeds the increment of the following cycle. An offset first lands on the edge after its strobe, and `pps_o` comes on the same edge as the rolled-over value. The bench drives inputs on the falling edge. It updates its own reference counters at the rising edge that consumes those inputs, and it compares every output on the next falling edge, so each result is checked in the cycle it is due. The directed checks of the deltas snapshot the counter at a falling edge and count these edges exactly.

// File: rtl/ptpc_pkg.sv
package ptpc_pkg;
  localparam int unsigned     TOD_NS_W   = 32;
  localparam longint unsigned NS_PER_SEC = 64'd1_000_000_000;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ptpc_rate.sv
// Period register plus rational drift accumulator; yields the base increment.
module ptpc_rate #(
  parameter int unsigned PERIOD_NS_W = 4,
  parameter int unsigned FNS_W       = 16,
  parameter int unsigned DRIFT_W     = 16,
  parameter int unsigned STEP_W      = 34,
  parameter int unsigned PERIOD_NUM  = 32,
  parameter int unsigned PERIOD_DEN  = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [PERIOD_NS_W-1:0] period_ns_i,
  input  logic [FNS_W-1:0]       period_fns_i,
  input  logic                   period_valid_i,
  input  logic [DRIFT_W-1:0]     drift_num_i,
  input  logic [DRIFT_W-1:0]     drift_den_i,
  input  logic                   drift_valid_i,
  output logic [STEP_W-1:0]      rate_o
);
  localparam longint unsigned SCALED  = longint'(PERIOD_NUM) << FNS_W;
  localparam longint unsigned DEF_INC = SCALED / PERIOD_DEN;
  localparam logic [PERIOD_NS_W-1:0] DEF_NS  = PERIOD_NS_W'(DEF_INC >> FNS_W);
  localparam logic [FNS_W-1:0]       DEF_FNS = FNS_W'(DEF_INC);
  localparam logic [DRIFT_W-1:0]     DEF_NUM = DRIFT_W'(SCALED % PERIOD_DEN);
  localparam logic [DRIFT_W-1:0]     DEF_DEN = DRIFT_W'(PERIOD_DEN);

  logic [PERIOD_NS_W-1:0] pns_q;
  logic [FNS_W-1:0]       pfns_q;
  logic [DRIFT_W-1:0]     num_q, den_q, cnt_q;
  logic                   due;

  assign due    = (den_q != '0) && (cnt_q == den_q - 1'b1);
  assign rate_o = STEP_W'({pns_q, pfns_q}) + (due ? STEP_W'(num_q) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pns_q  <= DEF_NS;
      pfns_q <= DEF_FNS;
    end else if (period_valid_i) begin
      pns_q  <= period_ns_i;
      pfns_q <= period_fns_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q <= DEF_NUM;
      den_q <= DEF_DEN;
      cnt_q <= '0;
    end else if (drift_valid_i) begin
      num_q <= drift_num_i;
      den_q <= drift_den_i;
      cnt_q <= '0;
    end else if (den_q != '0) begin
      cnt_q <= due ? '0 : cnt_q + 1'b1;
    end
  end

  assert_phase_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (den_q != '0) |-> (cnt_q < den_q));
  assert_period_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(period_valid_i) |-> (pns_q == $past(period_ns_i) && pfns_q == $past(period_fns_i)));
endmodule

// File: rtl/ptpc_adjust.sv
// Bounded offset: adds a fixed amount on each of N cycles.
module ptpc_adjust #(
  parameter int unsigned OFFSET_NS_W = 16,
  parameter int unsigned FNS_W       = 16,
  parameter int unsigned ADJ_CNT_W   = 16,
  parameter int unsigned STEP_W      = 34
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [OFFSET_NS_W-1:0] adj_ns_i,
  input  logic [FNS_W-1:0]       adj_fns_i,
  input  logic [ADJ_CNT_W-1:0]   adj_count_i,
  input  logic                   adj_valid_i,
  output logic [STEP_W-1:0]      adj_step_o,
  output logic                   active_o
);
  logic [OFFSET_NS_W+FNS_W-1:0] amt_q;
  logic [ADJ_CNT_W-1:0]         cnt_q;

  assign active_o   = (cnt_q != '0);
  assign adj_step_o = active_o ? STEP_W'(amt_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      amt_q <= '0;
      cnt_q <= '0;
    end else if (adj_valid_i) begin
      amt_q <= {adj_ns_i, adj_fns_i};
      cnt_q <= adj_count_i;
    end else if (active_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_active_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> ($past(adj_valid_i) || $past(cnt_q) == ADJ_CNT_W'(1)));
  assert_zero_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adj_valid_i && adj_count_i == '0) |=> !active_o);
endmodule

// File: rtl/ptpc_tod.sv
// Seconds / nanoseconds / fraction counter with one-billion rollover.
module ptpc_tod #(
  parameter int unsigned SEC_W  = 48,
  parameter int unsigned FNS_W  = 16,
  parameter int unsigned STEP_W = 34,
  localparam int unsigned SUB_W = ptpc_pkg::TOD_NS_W + FNS_W,
  localparam int unsigned TOD_W = SEC_W + SUB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STEP_W-1:0] inc_i,
  input  logic [TOD_W-1:0]  load_i,
  input  logic              load_valid_i,
  output logic [TOD_W-1:0]  tod_o,
  output logic              step_o,
  output logic              pps_o
);
  import ptpc_pkg::*;
  localparam logic [SUB_W:0]      LIM    = (SUB_W+1)'(NS_PER_SEC << FNS_W);
  localparam logic [TOD_NS_W-1:0] NS_MAX = TOD_NS_W'(NS_PER_SEC - 1);

  logic [SEC_W-1:0]    sec_q;
  logic [SUB_W-1:0]    sub_q;
  logic [SUB_W:0]      sum;
  logic                wrap;
  logic [TOD_NS_W-1:0] ld_ns, ld_ns_sat;

  assign sum       = {1'b0, sub_q} + (SUB_W+1)'(inc_i);
  assign wrap      = (sum >= LIM);
  assign ld_ns     = load_i[FNS_W +: TOD_NS_W];
  assign ld_ns_sat = (ld_ns > NS_MAX) ? NS_MAX : ld_ns;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= '0;
      sub_q  <= '0;
      step_o <= 1'b0;
      pps_o  <= 1'b0;
    end else if (load_valid_i) begin
      sec_q  <= load_i[TOD_W-1 -: SEC_W];
      sub_q  <= {ld_ns_sat, load_i[FNS_W-1:0]};
      step_o <= 1'b1;
      pps_o  <= 1'b0;
    end else begin
      sec_q  <= wrap ? sec_q + 1'b1 : sec_q;
      sub_q  <= wrap ? SUB_W'(sum - LIM) : SUB_W'(sum);
      step_o <= 1'b0;
      pps_o  <= wrap;
    end
  end

  assign tod_o = {sec_q, sub_q};

  assert_ns_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tod_o[FNS_W +: TOD_NS_W] <= NS_MAX);
  assert_pps_second_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pps_o |-> (sec_q == $past(sec_q) + 1'b1));
  assert_sec_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pps_o && !step_o) |-> $stable(sec_q));
  assert_step_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> $past(load_valid_i));
endmodule

// File: rtl/ptpc_rel.sv
// Flat relative nanosecond counter, no second wrap.
module ptpc_rel #(
  parameter int unsigned REL_W  = 64,
  parameter int unsigned STEP_W = 34
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STEP_W-1:0] inc_i,
  input  logic [REL_W-1:0]  load_i,
  input  logic              load_valid_i,
  output logic [REL_W-1:0]  rel_o,
  output logic              step_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_o  <= '0;
      step_o <= 1'b0;
    end else if (load_valid_i) begin
      rel_o  <= load_i;
      step_o <= 1'b1;
    end else begin
      rel_o  <= rel_o + REL_W'(inc_i);
      step_o <= 1'b0;
    end
  end

  assert_rel_monotone_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_o |-> (rel_o >= $past(rel_o)));
  assert_rel_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> (rel_o == $past(load_i)));
endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock #(
  parameter int unsigned SEC_W       = 48,
  parameter int unsigned FNS_W       = 16,
  parameter int unsigned REL_NS_W    = 48,
  parameter int unsigned PERIOD_NS_W = 4,
  parameter int unsigned OFFSET_NS_W = 16,
  parameter int unsigned ADJ_CNT_W   = 16,
  parameter int unsigned DRIFT_W     = 16,
  parameter int unsigned PERIOD_NUM  = 32,
  parameter int unsigned PERIOD_DEN  = 5,
  localparam int unsigned TOD_W  = SEC_W + ptpc_pkg::TOD_NS_W + FNS_W,
  localparam int unsigned REL_W  = REL_NS_W + FNS_W,
  localparam int unsigned BASE_W = ptpc_pkg::max2(PERIOD_NS_W, OFFSET_NS_W) + FNS_W,
  localparam int unsigned STEP_W = ptpc_pkg::max2(BASE_W, DRIFT_W) + 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [TOD_W-1:0]       tod_load_i,
  input  logic                   tod_load_valid_i,
  input  logic [REL_W-1:0]       rel_load_i,
  input  logic                   rel_load_valid_i,
  input  logic [PERIOD_NS_W-1:0] period_ns_i,
  input  logic [FNS_W-1:0]       period_fns_i,
  input  logic                   period_valid_i,
  input  logic [OFFSET_NS_W-1:0] adj_ns_i,
  input  logic [FNS_W-1:0]       adj_fns_i,
  input  logic [ADJ_CNT_W-1:0]   adj_count_i,
  input  logic                   adj_valid_i,
  input  logic [DRIFT_W-1:0]     drift_num_i,
  input  logic [DRIFT_W-1:0]     drift_den_i,
  input  logic                   drift_valid_i,
  output logic [TOD_W-1:0]       tod_o,
  output logic                   tod_step_o,
  output logic [REL_W-1:0]       rel_o,
  output logic                   rel_step_o,
  output logic                   pps_o,
  output logic                   adj_active_o
);
  logic [STEP_W-1:0] rate, adj_step, inc;

  ptpc_rate #(
    .PERIOD_NS_W(PERIOD_NS_W), .FNS_W(FNS_W), .DRIFT_W(DRIFT_W), .STEP_W(STEP_W),
    .PERIOD_NUM(PERIOD_NUM), .PERIOD_DEN(PERIOD_DEN)
  ) u_rate (
    .clk_i, .rst_ni,
    .period_ns_i, .period_fns_i, .period_valid_i,
    .drift_num_i, .drift_den_i, .drift_valid_i,
    .rate_o(rate)
  );

  ptpc_adjust #(
    .OFFSET_NS_W(OFFSET_NS_W), .FNS_W(FNS_W), .ADJ_CNT_W(ADJ_CNT_W), .STEP_W(STEP_W)
  ) u_adjust (
    .clk_i, .rst_ni,
    .adj_ns_i, .adj_fns_i, .adj_count_i, .adj_valid_i,
    .adj_step_o(adj_step),
    .active_o(adj_active_o)
  );

  assign inc = rate + adj_step;

  ptpc_tod #(.SEC_W(SEC_W), .FNS_W(FNS_W), .STEP_W(STEP_W)) u_tod (
    .clk_i, .rst_ni,
    .inc_i(inc),
    .load_i(tod_load_i),
    .load_valid_i(tod_load_valid_i),
    .tod_o,
    .step_o(tod_step_o),
    .pps_o
  );

  ptpc_rel #(.REL_W(REL_W), .STEP_W(STEP_W)) u_rel (
    .clk_i, .rst_ni,
    .inc_i(inc),
    .load_i(rel_load_i),
    .load_valid_i(rel_load_valid_i),
    .rel_o,
    .step_o(rel_step_o)
  );

  assert_same_rate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rel_step_o && !tod_step_o && !pps_o) |->
      ((rel_o - $past(rel_o)) == 64'(tod_o[47:0] - $past(tod_o[47:0]))));
endmodule

// File: tb/ptp_tod_clock_bench.sv
`timescale 1ns/1ps
module ptp_tod_clock_bench;
  localparam longint unsigned LIM = 64'd1_000_000_000 << 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [95:0] tod_load = '0;
  logic        tod_load_valid = 1'b0;
  logic [63:0] rel_load = '0;
  logic        rel_load_valid = 1'b0;
  logic [3:0]  period_ns = '0;
  logic [15:0] period_fns = '0;
  logic        period_valid = 1'b0;
  logic [15:0] adj_ns = '0, adj_fns = '0, adj_count = '0;
  logic        adj_valid = 1'b0;
  logic [15:0] drift_num = '0, drift_den = '0;
  logic        drift_valid = 1'b0;
  logic [95:0] tod;
  logic [63:0] rel;
  logic        tod_step, rel_step, pps, adj_active;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // reference state
  longint unsigned m_sec, m_sub, m_rel, m_pns, m_pfns, m_dnum, m_dden, m_dcnt, m_acnt, m_aamt;
  bit m_tstep, m_rstep, m_pps;

  always #5 clk = ~clk;

  ptp_tod_clock u_ptp_tod_clock (
    .clk_i(clk), .rst_ni(rst_ni),
    .tod_load_i(tod_load), .tod_load_valid_i(tod_load_valid),
    .rel_load_i(rel_load), .rel_load_valid_i(rel_load_valid),
    .period_ns_i(period_ns), .period_fns_i(period_fns), .period_valid_i(period_valid),
    .adj_ns_i(adj_ns), .adj_fns_i(adj_fns), .adj_count_i(adj_count), .adj_valid_i(adj_valid),
    .drift_num_i(drift_num), .drift_den_i(drift_den), .drift_valid_i(drift_valid),
    .tod_o(tod), .tod_step_o(tod_step), .rel_o(rel), .rel_step_o(rel_step),
    .pps_o(pps), .adj_active_o(adj_active)
  );

  task automatic check(bit ok, string req, string what, logic [191:0] act, logic [191:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void model_reset();
    m_sec = 0; m_sub = 0; m_rel = 0;
    m_pns = 6; m_pfns = 64'h6666; m_dnum = 2; m_dden = 5; m_dcnt = 0;
    m_acnt = 0; m_aamt = 0; m_tstep = 0; m_rstep = 0; m_pps = 0;
  endfunction

  function automatic void model_edge();
    longint unsigned extra, inc, sum, ld_ns;
    extra = (m_dden != 0 && m_dcnt == m_dden - 1) ? m_dnum : 0;
    inc = (m_pns << 16) + m_pfns + extra + ((m_acnt != 0) ? m_aamt : 0);
    if (drift_valid) begin m_dnum = drift_num; m_dden = drift_den; m_dcnt = 0; end
    else if (m_dden != 0) m_dcnt = (m_dcnt == m_dden - 1) ? 0 : m_dcnt + 1;
    if (period_valid) begin m_pns = period_ns; m_pfns = period_fns; end
    if (adj_valid) begin m_aamt = {adj_ns, adj_fns}; m_acnt = adj_count; end
    else if (m_acnt != 0) m_acnt--;
    if (tod_load_valid) begin
      ld_ns = tod_load[47:16];
      if (ld_ns > 999_999_999) ld_ns = 999_999_999;
      m_sec = tod_load[95:48]; m_sub = (ld_ns << 16) | tod_load[15:0];
      m_tstep = 1; m_pps = 0;
    end else begin
      sum = m_sub + inc; m_tstep = 0;
      if (sum >= LIM) begin m_sub = sum - LIM; m_sec = (m_sec + 1) & 64'hFFFF_FFFF_FFFF; m_pps = 1; end
      else begin m_sub = sum; m_pps = 0; end
    end
    if (rel_load_valid) begin m_rel = rel_load; m_rstep = 1; end
    else begin m_rel = m_rel + inc; m_rstep = 0; end
  endfunction

  task automatic tick();
    logic [191:0] a, e;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    a = {28'd0, tod, rel, tod_step, rel_step, pps, adj_active};
    e = {28'd0, m_sec[47:0], m_sub[47:0], m_rel, m_tstep, m_rstep, m_pps, m_acnt != 0};
    check(a == e, cur_req, "outputs", a, e);
    tod_load_valid = 0; rel_load_valid = 0; period_valid = 0;
    adj_valid = 0; drift_valid = 0;
  endtask

  initial begin
    longint unsigned snap;
    bit seen;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    check({tod, rel, tod_step, rel_step, pps, adj_active} == '0, "R1", "reset",
          {tod[63:0], rel, 64'(tod_step)}, '0);
    rst_ni = 1'b1;

    cur_req = "R2";
    repeat (10000) tick();
    check(rel == 64'd4194304000, "R1", "default rate 10000 cycles", rel, 64'd4194304000);
    check(tod == 96'd4194304000, "R2", "tod equals rel", tod, 96'd4194304000);

    // R10 layout
    cur_req = "R5";
    tod_load = {48'd5, 32'd123, 16'd7}; tod_load_valid = 1; tick();
    check(tod[95:48] == 5 && tod[47:16] == 123 && tod[15:0] == 7 && tod_step,
          "R10", "field layout", tod, {48'd5, 32'd123, 16'd7});
    tick();
    check(!tod_step, "R5", "step one cycle", tod_step, 0);

    // R7 rollover
    cur_req = "R7";
    tod_load = {48'd9, 32'd999_999_990, 16'd0}; tod_load_valid = 1; tick();
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      tick();
      if (pps) begin
        seen = 1;
        check(tod[95:48] == 10 && tod[47:16] < 7, "R7", "value at pps", tod[95:16], {48'd10, 32'd0});
      end
    end
    check(seen, "R7", "pps seen", seen, 1);

    // R6 rel load leaves tod alone (model compares tod too)
    cur_req = "R6";
    rel_load = 64'(64'd999_999_990 << 16); rel_load_valid = 1; tick();
    check(rel == (64'd999_999_990 << 16) && rel_step && !tod_step, "R6", "rel load",
          rel, 64'd999_999_990 << 16);
    cur_req = "R8";
    repeat (6) tick();
    check((rel >> 16) >= 64'd1_000_000_000, "R8", "no wrap", rel >> 16, 64'd1_000_000_000);

    // R3 disable, R4 period
    cur_req = "R3";
    drift_den = 0; drift_num = 9; drift_valid = 1; tick();
    cur_req = "R4";
    period_ns = 6; period_fns = 16'h6624; period_valid = 1; tick();
    snap = rel; tick();
    check(rel - snap == 64'h66624, "R4", "new period delta", rel - snap, 64'h66624);

    cur_req = "R3";
    drift_num = 20; drift_den = 5; drift_valid = 1; tick();
    snap = rel; repeat (5) tick();
    check(rel - snap == 5 * 64'h66624 + 20, "R3", "drift 20/5", rel - snap, 5 * 64'h66624 + 20);
    drift_den = 0; drift_valid = 1; tick();

    // R9 offset
    cur_req = "R9";
    adj_ns = 2; adj_fns = 16'h0010; adj_count = 3; adj_valid = 1; tick();
    check(adj_active, "R9", "active after strobe", adj_active, 1);
    snap = rel; tick(); tick();
    check(adj_active, "R9", "active at 2", adj_active, 1);
    tick();
    check(!adj_active, "R9", "inactive after N", adj_active, 0);
    check(rel - snap == 3 * (64'h66624 + 64'h20010), "R9", "offset sum",
          rel - snap, 3 * (64'h66624 + 64'h20010));
    adj_count = 0; adj_valid = 1; tick();
    snap = rel; tick();
    check(!adj_active && rel - snap == 64'h66624, "R9", "zero count", rel - snap, 64'h66624);

    // R5 saturation
    cur_req = "R5";
    tod_load = {48'd1, 32'hFFFF_FFFF, 16'h1234}; tod_load_valid = 1; tick();
    check(tod[47:16] == 999_999_999, "R5", "saturate ns", tod[47:16], 32'd999_999_999);

    // mixed random
    cur_req = "R2";
    for (int i = 0; i < 20000; i++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 2) begin
        tod_load = {16'd0, 32'($urandom), 32'(999_999_000 + $urandom % 2000), 16'($urandom)};
        tod_load_valid = 1;
      end else if (r < 4) begin
        rel_load = {32'($urandom % 1024), 32'($urandom)}; rel_load_valid = 1;
      end else if (r < 6) begin
        period_ns = 4'(5 + $urandom % 3); period_fns = 16'($urandom); period_valid = 1;
      end else if (r < 8) begin
        drift_num = 16'($urandom % 32); drift_den = 16'($urandom % 8); drift_valid = 1;
      end else if (r < 11) begin
        adj_ns = 16'($urandom % 4); adj_fns = 16'($urandom); adj_count = 16'($urandom % 24);
        adj_valid = 1;
      end
      tick();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule